// File: doc/BRIEF.md
# Sine Tone Synthesizer with Pulse-Width Output

This block makes an audio-range sine tone on one digital pin. A free-running period counter fixes the sample rate. Once per period a phase accumulator advances by a tuning word. The top bits of the accumulator address a sine code table, and the code read out becomes the pulse width of the following period. An external RC low-pass filter turns the pulse train into a sine wave; that filter is not part of this block.

The tone frequency is `tune_i * f_clk / (PERIOD * 2^ACC_W)`. With the default settings the tick is about 476.84 ns, which gives 10485.76 samples per second. Each tuning-word LSB is then 0.000625 Hz, so the word for a tone equals its frequency in hundredths of a hertz shifted left by four (254.1 Hz needs 406560).

Parameters select the variant. The default uses a 24-bit accumulator, a 200-tick period and a 256-entry table with codes from 0 to 200. The coarse setting uses a 16-bit accumulator, a 256-tick period and a 64-entry table (`ACC_W=16, PERIOD=256, IDX_W=6, AMP=255`).

Top module: `dds_sine_pwm`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `pwm_o` and `sample_o` are low. The first output window after reset has zero high cycles.
- R2: While `en_i` is high, `sample_o` is a one-cycle pulse every PERIOD clocks. It marks the first cycle of each output window.
- R3: In each output window (the strobe cycle and the PERIOD-1 cycles after it), `pwm_o` is high for exactly as many cycles as that window's duty code. A code of 0 keeps the pin low for the whole window, and a code of PERIOD keeps it high for the whole window.
- R4: Number the windows after reset or re-enable as n = 0, 1, 2, and so on. Window n > 0 uses the duty code `T[acc >> (ACC_W-IDX_W)]`, where acc = acc0 + n·tune modulo 2^ACC_W and acc0 is the phase when the run started (0 after reset).
- R5: Table entry i equals `floor(AMP/2 · (1 + sin(2πi/2^IDX_W)) + 0.5)`. The codes therefore run from 0 to AMP, centred on AMP/2.
- R6: The tuning word is sampled once per period. A value applied at the start of a window sets the step between that window's phase and the next window's phase.
- R7: The accumulator wraps modulo 2^ACC_W. A tuning word of 2^ACC_W − k steps the phase backwards by k.
- R8: While `en_i` is low, `pwm_o` and `sample_o` stay low and the accumulator keeps its phase. After `en_i` returns high, the first window has zero high cycles, and later windows continue from the kept phase.
- R9: The number of samples between upward mid-level crossings of the duty sequence, multiplied by the tuning word, is within one tuning word of 2^ACC_W.
- R10: With a quarter-turn tuning word (2^(ACC_W-2)) starting from phase 0, the duty codes after the first window cycle through AMP, AMP/2, 0, AMP/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one tick of the PWM period counter |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low stops the counter and silences the output |
| tune_i | input | ACC_W | Tuning word added to the phase once per period |
| pwm_o | output | 1 | Registered pulse-width output carrying the sine |
| sample_o | output | 1 | Registered strobe on the first cycle of each output window |

## Verification
Several properties are checked on every cycle:
- The period counter stays in range.
- The strobe never lasts two cycles.
- The duty code never exceeds PERIOD, and a zero code keeps the pin low.
- With the enable low, both outputs are silent.
- The phase changes only at its one update point in each period.

Other behaviour only the bench scenarios can show:
- The window-by-window duty sequence against an independent accumulator model, including backward wrap and a change of tuning word during a run.
- Keeping the phase across an enable gap.
- The measured tone period against the tuning word.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Sine code for table slot idx of n, spanning 0..amp around amp/2.
  function automatic int sine_code(input int idx, input int n, input int amp);
    real ang;
    real v;
    ang = TWO_PI * real'(idx) / real'(n);
    v   = (real'(amp) / 2.0) * (1.0 + $sin(ang));
    return int'($floor(v + 0.5));
  endfunction

  // Width needed to hold values 0..v.
  function automatic int width_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/tone_period_timer.sv
module tone_period_timer #(
  parameter int PERIOD = 200,
  localparam int CNT_W = tone_pkg::width_for(PERIOD - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             adv_tick,
  output logic             end_tick,
  output logic             start_tick
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] ADV  = CNT_W'(PERIOD - 3);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // The phase advances three ticks early, leaving room for the table read
  // and the duty load before the boundary.
  assign adv_tick   = en && (cnt == ADV);
  assign end_tick   = en && (cnt == LAST);
  assign start_tick = en && (cnt == '0);

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/tone_phase_accum.sv
module tone_phase_accum #(
  parameter int ACC_W = 24,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [ACC_W-1:0] tune,
  output logic [IDX_W-1:0] idx
);

  logic [ACC_W-1:0] acc;

  // Free wrap modulo 2^ACC_W; only reset clears it.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (adv) begin
      acc <= acc + tune;
    end
  end

  assign idx = acc[ACC_W-1 -: IDX_W];

  a_r6_phase_held_off_tick: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(acc));

endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
  parameter int IDX_W  = 8,
  parameter int AMP    = 200,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  addr,
  output logic [CODE_W-1:0] code
);

  localparam int DEPTH = 1 << IDX_W;

  logic [CODE_W-1:0] table_mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      table_mem[i] = CODE_W'(tone_pkg::sine_code(i, DEPTH, AMP));
    end
  end

  // Registered read so the table maps onto block RAM.
  always_ff @(posedge clk) begin
    code <= table_mem[addr];
  end

endmodule

// File: rtl/tone_pwm_out.sv
module tone_pwm_out #(
  parameter int PERIOD = 200,
  parameter int CODE_W = 8,
  localparam int CNT_W = tone_pkg::width_for(PERIOD - 1),
  localparam int CMP_W = (CNT_W > CODE_W) ? CNT_W : CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              end_tick,
  input  logic              start_tick,
  input  logic [CODE_W-1:0] next_code,
  output logic              pwm,
  output logic              strobe
);

  logic [CODE_W-1:0] duty;

  // The duty is zero after reset and while idle. It loads only at the
  // period boundary.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      duty <= '0;
    end else if (end_tick) begin
      duty <= next_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm    <= 1'b0;
      strobe <= 1'b0;
    end else begin
      pwm    <= en && (CMP_W'(cnt) < CMP_W'(duty));
      strobe <= start_tick;
    end
  end

  a_r3_duty_within_period: assert property (@(posedge clk) disable iff (rst)
    CMP_W'(duty) <= CMP_W'(PERIOD));

  a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
    (en && duty == '0) |=> !pwm);

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

  a_r8_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwm && !strobe));

endmodule

// File: rtl/dds_sine_pwm.sv
module dds_sine_pwm #(
  parameter int PERIOD = 200,
  parameter int ACC_W  = 24,
  parameter int IDX_W  = 8,
  parameter int AMP    = PERIOD,
  localparam int CODE_W = tone_pkg::width_for(AMP),
  localparam int CNT_W  = tone_pkg::width_for(PERIOD - 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] tune_i,
  output logic             pwm_o,
  output logic             sample_o
);

  logic [CNT_W-1:0]  cnt;
  logic              adv_tick;
  logic              end_tick;
  logic              start_tick;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] code;

  tone_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk        (clk_i),
    .rst        (rst_i),
    .en         (en_i),
    .cnt        (cnt),
    .adv_tick   (adv_tick),
    .end_tick   (end_tick),
    .start_tick (start_tick)
  );

  tone_phase_accum #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_accum (
    .clk  (clk_i),
    .rst  (rst_i),
    .adv  (adv_tick),
    .tune (tune_i),
    .idx  (idx)
  );

  tone_sine_rom #(.IDX_W(IDX_W), .AMP(AMP), .CODE_W(CODE_W)) u_rom (
    .clk  (clk_i),
    .addr (idx),
    .code (code)
  );

  tone_pwm_out #(.PERIOD(PERIOD), .CODE_W(CODE_W)) u_out (
    .clk        (clk_i),
    .rst        (rst_i),
    .en         (en_i),
    .cnt        (cnt),
    .end_tick   (end_tick),
    .start_tick (start_tick),
    .next_code  (code),
    .pwm        (pwm_o),
    .strobe     (sample_o)
  );

endmodule

// File: tb/dds_sine_pwm_test.sv
module dds_sine_pwm_test;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 200;
  localparam int ACC_W      = 24;
  localparam int IDX_W      = 8;
  localparam int AMP        = 200;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b1;
  logic [ACC_W-1:0] tw  = '0;
  logic             pwm;
  logic             stb;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_sine_pwm #(.PERIOD(PERIOD), .ACC_W(ACC_W), .IDX_W(IDX_W), .AMP(AMP)) uut (
    .clk_i    (clk),
    .rst_i    (rst),
    .en_i     (en),
    .tune_i   (tw),
    .pwm_o    (pwm),
    .sample_o (stb)
  );

  int               n_chk  = 0;
  int               n_fail = 0;
  int               exp_q[$];
  int               duties[$];
  logic [ACC_W-1:0] macc   = '0;
  bit               first  = 1'b1;
  bit               done   = 1'b0;

  function automatic int ref_code(input int i);
    real v;
    v = (real'(AMP) / 2.0) * (1.0 + $sin(6.283185307179586 * real'(i) / real'(1 << IDX_W)));
    return int'($floor(v + 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // The driver side pushes the model's expected duty. The monitor side
  // measures the window and pops it for comparison.
  task automatic run_windows(input int n, input string req);
    for (int w = 0; w < n; w++) begin
      int hi;
      int extra;
      int e;
      while (!stb) @(negedge clk);
      e = first ? 0 : ref_code(int'(macc[ACC_W-1 -: IDX_W]));
      exp_q.push_back(e);
      hi = 0;
      extra = 0;
      for (int i = 0; i < PERIOD; i++) begin
        if (pwm) hi++;
        if (i > 0 && stb) extra++;
        @(negedge clk);
      end
      check(stb == 1'b1 && extra == 0, "R2 strobe spacing", extra, 0);
      macc  = macc + tw;
      first = 1'b0;
      duties.push_back(hi);
      e = exp_q.pop_front();
      check(hi == e, {req, " R3 high count"}, hi, e);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tw = ACC_W'(1) << (ACC_W - 2);
    repeat (5) @(negedge clk);
    check(pwm == 1'b0 && stb == 1'b0, "R1 reset outputs", {pwm, stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pwm == 1'b0, "R1 after release", pwm, 0);

    // R1: window 0 zero, then R10 quarter-turn extremes.
    run_windows(6, "R1 R10 R4");

    // R6: a new word applied at a window start.
    tw = ACC_W'(406560);
    run_windows(3, "R6");

    // R9: tone period measured from the duty stream.
    duties.delete();
    run_windows(100, "R4");
    begin
      int last;
      int crossings;
      last = -1;
      crossings = 0;
      for (int i = 1; i < duties.size(); i++) begin
        if (duties[i-1] < AMP/2 && duties[i] >= AMP/2) begin
          if (last >= 0) begin
            longint span;
            longint full;
            span = longint'(i - last) * longint'(tw);
            full = longint'(1) << ACC_W;
            crossings++;
            check((span - full <= longint'(tw)) && (full - span <= longint'(tw)),
                  "R9 tone period", span, full);
          end
          last = i;
        end
      end
      check(crossings >= 1, "R9 crossings found", crossings, 1);
    end

    // R7: backward steps through the wrap.
    tw = ACC_W'((longint'(1) << ACC_W) - (longint'(1) << (ACC_W - 2)));
    run_windows(8, "R7");

    // R8: idle period, then resume with the phase kept.
    while (!stb) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      check(pwm == 1'b0 && stb == 1'b0, "R8 idle outputs", {pwm, stb}, 0);
      @(negedge clk);
    end
    en = 1'b1;
    first = 1'b1;
    tw = ACC_W'(5) << (ACC_W - IDX_W);
    run_windows(4, "R8");

    // R5: sweep table slots in steps of five.
    run_windows(60, "R5");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule